// File: doc/BRIEF.md
# Register-Mapped Byte-Stream Frame Mailbox

This block is a small network-style peripheral on a 32-bit register bus. It sits between a host and a network-side byte stream and moves whole frames one byte per register access. Frames arriving on the network side are captured into an internal receive buffer. The host learns the frame length from a count register and then drains the bytes one at a time through a data register. The count drops with every read, so it always shows how many bytes remain.

For transmission the host first writes a byte count and then writes exactly that many bytes, one per access, to a transmit data register. When the last counted byte has been written, the block streams the frame out on a valid/ready byte interface and marks the final byte. It clears the transmit count once the last byte has been handed over. A read-only busy flag is set while a frame is partly captured or is being streamed out. A 64-bit identity word lets software probe for the block. Interrupt control lives in a separate block, which reports through one input whether its receive-available flag is still set. While that flag is set, no new frame is taken in.

Top module: `pkt_mailbox`

## Requirements
- R1: Offset 0x00 reads the low 32 bits and offset 0x04 the high 32 bits of the identity parameter. The default identity is the text "MBOXLNK1", with its first character in bits 7:0 and each later character one byte higher.
- R2: Offset 0x18 reads the INFO_WORD parameter. Offset 0x14, the tx data offset 0x20 and every unmapped or unaligned offset read as zero. Writes to any offset other than 0x10 and 0x20 change nothing.
- R3: A frame arrives as bytes accepted when rx_valid and rx_ready are both high, with rx_last on the final byte. If its length does not exceed DEPTH, the rx count register (0x0C) holds that length from the cycle after the last byte is accepted.
- R4: Each read of rx data (0x1C) while the rx count is nonzero returns the next byte in arrival order in bits 7:0, with bits 31:8 zero, and lowers the count by exactly one.
- R5: A read of rx data while the rx count is zero returns zero and leaves the count at zero.
- R6: No new frame starts while the rx count is nonzero or the pending-flag input is high: rx_ready stays low, and the count and the buffered bytes are unchanged.
- R7: A frame longer than DEPTH bytes is still consumed in full, but it is dropped: the rx count stays zero afterwards. A frame of exactly DEPTH bytes is kept.
- R8: A write to tx count (0x10) takes effect only while the tx count is zero, no frame is streaming, and the written value is between 1 and DEPTH. Any other such write is ignored.
- R9: Bits 7:0 of each write to tx data (0x20) are buffered. tx_valid stays low until the counted number of bytes has been written. The bytes then leave in write order, with tx_last high on the final byte only. Extra writes to tx data made while the frame is streaming are ignored.
- R10: While tx_valid is high and tx_ready is low, the byte and tx_last hold steady. The tx count reads zero from the cycle after the last byte is accepted.
- R11: Busy (0x08, bit 0) is 1 while a receive frame has been started but not finished, and while a transmit frame is streaming. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset within the 0x40 window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as bus_sel |
| net_rx_valid | input | 1 | Receive byte present |
| net_rx_ready | output | 1 | Block can accept a receive byte |
| net_rx_data | input | 8 | Receive byte |
| net_rx_last | input | 1 | Receive byte ends the frame |
| rx_flag_pending | input | 1 | Receive-available interrupt flag from the interrupt block |
| net_tx_valid | output | 1 | Transmit byte present |
| net_tx_ready | input | 1 | Sink takes the transmit byte |
| net_tx_data | output | 8 | Transmit byte |
| net_tx_last | output | 1 | Transmit byte ends the frame |

## Verification
The assertions check the following on every cycle: the receive side is blocked while bytes remain; each data read steps the count down by exactly one, or leaves it at zero when the buffer is empty; the upper read bits of the data register are clear; a stalled transmit byte holds steady; the tx count clears after the final handshake; and busy covers streaming. Only the bench scenarios can show the things that depend on content and length: that bytes come out in arrival or write order, that an oversized frame is dropped while an exactly full one is kept, that bad count writes and extra data writes are ignored, and that the identity and info words read back correctly.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    // Register offsets; software decodes these, so they are fixed.
    localparam logic [5:0] OFS_ID_LO   = 6'h00;
    localparam logic [5:0] OFS_ID_HI   = 6'h04;
    localparam logic [5:0] OFS_BUSY    = 6'h08;
    localparam logic [5:0] OFS_RX_CNT  = 6'h0C;
    localparam logic [5:0] OFS_TX_CNT  = 6'h10;
    localparam logic [5:0] OFS_IRQ_CTL = 6'h14;
    localparam logic [5:0] OFS_INFO    = 6'h18;
    localparam logic [5:0] OFS_RX_DATA = 6'h1C;
    localparam logic [5:0] OFS_TX_DATA = 6'h20;

    // Largest frame length a count register can express.
    localparam int unsigned MAX_FRAME = 65536;
    localparam int unsigned CNT_W     = $clog2(MAX_FRAME + 1);

    // Side-effect strobes produced by the register decoder.
    typedef struct packed {
        logic rx_pop;
        logic tx_cnt_wr;
        logic tx_dat_wr;
    } bus_strobe_t;

endpackage

// File: rtl/mbox_rx_path.sv
module mbox_rx_path #(
    parameter int unsigned DEPTH = 2048,
    parameter int unsigned CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_byte,
    input  logic             in_last,
    input  logic             in_hold,
    input  logic             pop,
    output logic [7:0]       head_byte,
    output logic [CNT_W-1:0] remain,
    output logic             capturing
);

    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned LW = $clog2(DEPTH + 2);

    typedef struct packed {
        logic             active;
        logic [LW-1:0]    len;
        logic [AW-1:0]    rd_ptr;
        logic [CNT_W-1:0] count;
    } rx_state_t;

    rx_state_t   st_d, st_q;
    logic [7:0]  store_q [DEPTH];
    logic        take;
    logic        keep;
    logic [LW-1:0] len_inc;

    always_comb begin
        st_d     = st_q;
        in_ready = st_q.active | ((st_q.count == '0) & ~in_hold);
        take     = in_valid & in_ready;
        keep     = take & (st_q.len < LW'(DEPTH));
        len_inc  = (st_q.len <= LW'(DEPTH)) ? st_q.len + 1'b1 : st_q.len;

        if (take) begin
            if (in_last) begin
                st_d.active = 1'b0;
                st_d.len    = '0;
                if (len_inc <= LW'(DEPTH)) begin
                    st_d.count  = CNT_W'(len_inc);
                    st_d.rd_ptr = '0;
                end
            end else begin
                st_d.active = 1'b1;
                st_d.len    = len_inc;
            end
        end else if (pop && (st_q.count != '0)) begin
            st_d.count  = st_q.count - 1'b1;
            st_d.rd_ptr = st_q.rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (keep) begin
            store_q[st_q.len[AW-1:0]] <= in_byte;
        end
    end

    assign head_byte = (st_q.count != '0) ? store_q[st_q.rd_ptr] : 8'h00;
    assign remain    = st_q.count;
    assign capturing = st_q.active;

endmodule

// File: rtl/mbox_tx_path.sv
module mbox_tx_path #(
    parameter int unsigned DEPTH = 2048,
    parameter int unsigned CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_wr,
    input  logic             dat_wr,
    input  logic [31:0]      wdata,
    output logic [CNT_W-1:0] pending,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_byte,
    output logic             out_last,
    output logic             streaming
);

    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned LW = $clog2(DEPTH + 2);

    typedef struct packed {
        logic             sending;
        logic [CNT_W-1:0] count;
        logic [LW-1:0]    fill;
        logic [AW-1:0]    send_ptr;
    } tx_state_t;

    tx_state_t   st_d, st_q;
    logic [7:0]  store_q [DEPTH];
    logic        store;
    logic        cnt_ok;
    logic        at_end;

    always_comb begin
        st_d   = st_q;
        store  = 1'b0;
        cnt_ok = (wdata != 32'd0) && (wdata <= 32'(DEPTH));
        at_end = st_q.sending && ((CNT_W'(st_q.send_ptr) + 1'b1) == st_q.count);

        if (!st_q.sending) begin
            if (cnt_wr && (st_q.count == '0) && cnt_ok) begin
                st_d.count = wdata[CNT_W-1:0];
                st_d.fill  = '0;
            end else if (dat_wr && (st_q.count != '0) && (CNT_W'(st_q.fill) < st_q.count)) begin
                store     = 1'b1;
                st_d.fill = st_q.fill + 1'b1;
                if ((CNT_W'(st_q.fill) + 1'b1) == st_q.count) begin
                    st_d.sending  = 1'b1;
                    st_d.send_ptr = '0;
                end
            end
        end else if (out_ready) begin
            if (at_end) begin
                st_d = '0;
            end else begin
                st_d.send_ptr = st_q.send_ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (store) begin
            store_q[st_q.fill[AW-1:0]] <= wdata[7:0];
        end
    end

    assign pending   = st_q.count;
    assign out_valid = st_q.sending;
    assign out_byte  = st_q.sending ? store_q[st_q.send_ptr] : 8'h00;
    assign out_last  = at_end;
    assign streaming = st_q.sending;

endmodule

// File: rtl/mbox_reg_decode.sv
module mbox_reg_decode
    import mbox_pkg::*;
#(
    parameter logic [63:0] ID_WORD   = 64'h314B_4E4C_584F_424D,
    parameter logic [31:0] INFO_WORD = 32'h0000_0001
) (
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [5:0]       bus_addr,
    input  logic             busy,
    input  logic [CNT_W-1:0] rx_remain,
    input  logic [CNT_W-1:0] tx_pending,
    input  logic [7:0]       rx_head,
    output logic [31:0]      rdata,
    output bus_strobe_t      strobe
);

    logic rd_en;
    logic wr_en;

    always_comb begin
        rd_en  = bus_sel & ~bus_wr;
        wr_en  = bus_sel & bus_wr;
        rdata  = 32'd0;
        strobe = '0;

        if (rd_en) begin
            unique case (bus_addr)
                OFS_ID_LO:   rdata = ID_WORD[31:0];
                OFS_ID_HI:   rdata = ID_WORD[63:32];
                OFS_BUSY:    rdata = {31'd0, busy};
                OFS_RX_CNT:  rdata = 32'(rx_remain);
                OFS_TX_CNT:  rdata = 32'(tx_pending);
                OFS_INFO:    rdata = INFO_WORD;
                OFS_RX_DATA: rdata = {24'd0, rx_head};
                default:     rdata = 32'd0;
            endcase
        end

        strobe.rx_pop    = rd_en & (bus_addr == OFS_RX_DATA);
        strobe.tx_cnt_wr = wr_en & (bus_addr == OFS_TX_CNT);
        strobe.tx_dat_wr = wr_en & (bus_addr == OFS_TX_DATA);
    end

endmodule

// File: rtl/pkt_mailbox.sv
module pkt_mailbox
    import mbox_pkg::*;
#(
    parameter int unsigned DEPTH     = 2048,
    parameter logic [63:0] ID_WORD   = 64'h314B_4E4C_584F_424D,
    parameter logic [31:0] INFO_WORD = 32'h0000_0001
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [5:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        net_rx_valid,
    output logic        net_rx_ready,
    input  logic [7:0]  net_rx_data,
    input  logic        net_rx_last,
    input  logic        rx_flag_pending,
    output logic        net_tx_valid,
    input  logic        net_tx_ready,
    output logic [7:0]  net_tx_data,
    output logic        net_tx_last
);

    bus_strobe_t      strobe;
    logic [CNT_W-1:0] rx_count;
    logic [CNT_W-1:0] tx_count;
    logic [7:0]       rx_head;
    logic             rx_active;
    logic             tx_active;
    logic             busy;

    assign busy = rx_active | tx_active;

    mbox_rx_path #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (net_rx_valid),
        .in_ready  (net_rx_ready),
        .in_byte   (net_rx_data),
        .in_last   (net_rx_last),
        .in_hold   (rx_flag_pending),
        .pop       (strobe.rx_pop),
        .head_byte (rx_head),
        .remain    (rx_count),
        .capturing (rx_active)
    );

    mbox_tx_path #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_wr    (strobe.tx_cnt_wr),
        .dat_wr    (strobe.tx_dat_wr),
        .wdata     (bus_wdata),
        .pending   (tx_count),
        .out_valid (net_tx_valid),
        .out_ready (net_tx_ready),
        .out_byte  (net_tx_data),
        .out_last  (net_tx_last),
        .streaming (tx_active)
    );

    mbox_reg_decode #(.ID_WORD(ID_WORD), .INFO_WORD(INFO_WORD)) u_dec (
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .busy       (busy),
        .rx_remain  (rx_count),
        .tx_pending (tx_count),
        .rx_head    (rx_head),
        .rdata      (bus_rdata),
        .strobe     (strobe)
    );

endmodule

// File: rtl/mbox_chk.sv
module mbox_chk #(
    parameter int unsigned CW = 17
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sel,
    input logic          bus_wr,
    input logic [5:0]    bus_addr,
    input logic [31:0]   bus_rdata,
    input logic          net_rx_valid,
    input logic          net_rx_ready,
    input logic          net_rx_last,
    input logic          net_tx_valid,
    input logic          net_tx_ready,
    input logic [7:0]    net_tx_data,
    input logic          net_tx_last,
    input logic [CW-1:0] rx_count,
    input logic [CW-1:0] tx_count,
    input logic          busy
);

    logic data_rd;
    logic frame_end;
    assign data_rd   = bus_sel && !bus_wr && (bus_addr == 6'h1C);
    assign frame_end = net_rx_valid && net_rx_ready && net_rx_last;

    // R4
    rx_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd |-> (bus_rdata[31:8] == 24'd0));

    // R4
    rx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && rx_count != '0) |=> (rx_count == $past(rx_count) - 1'b1));

    // R5
    rx_empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && rx_count == '0 && !frame_end) |=> (rx_count == '0));

    // R6
    rx_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count != '0) |-> !net_rx_ready);

    // R9
    tx_last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        net_tx_last |-> net_tx_valid);

    // R10
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (net_tx_valid && !net_tx_ready) |=>
            (net_tx_valid && $stable(net_tx_data) && $stable(net_tx_last)));

    // R10
    tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (net_tx_valid && net_tx_ready && net_tx_last) |=> (tx_count == '0));

    // R11
    busy_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        net_tx_valid |-> busy);

endmodule

bind pkt_mailbox mbox_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_rdata    (bus_rdata),
    .net_rx_valid (net_rx_valid),
    .net_rx_ready (net_rx_ready),
    .net_rx_last  (net_rx_last),
    .net_tx_valid (net_tx_valid),
    .net_tx_ready (net_tx_ready),
    .net_tx_data  (net_tx_data),
    .net_tx_last  (net_tx_last),
    .rx_count     (rx_count),
    .tx_count     (tx_count),
    .busy         (busy)
);

// File: tb/pkt_mailbox_test.sv
module pkt_mailbox_test;

    localparam int DEPTH = 16;
    localparam logic [31:0] INFO = 32'hA5C3_0042;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0, rx_ready, rx_last = 1'b0, rx_hold = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        tx_valid, tx_ready = 1'b0, tx_last;
    logic [7:0]  tx_data;

    always #10 clk = ~clk;

    pkt_mailbox #(.DEPTH(DEPTH), .INFO_WORD(INFO)) uut (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .net_rx_valid(rx_valid), .net_rx_ready(rx_ready), .net_rx_data(rx_data),
        .net_rx_last(rx_last), .rx_flag_pending(rx_hold),
        .net_tx_valid(tx_valid), .net_tx_ready(tx_ready),
        .net_tx_data(tx_data), .net_tx_last(tx_last)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] frm[$];
    logic [7:0] tx_seen[$];
    bit         tx_last_seen[$];
    bit         tx_rand = 1'b1;
    bit         tx_force = 1'b0;

    task automatic chk_eq(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic longint exp_rx_count(input int len);
        return (len <= DEPTH) ? len : 0;
    endfunction

    function automatic logic [7:0] id_char(input int idx);
        string s = "MBOXLNK1";
        return s[idx];
    endfunction

    function automatic logic [31:0] id_half(input int base);
        return {id_char(base + 3), id_char(base + 2), id_char(base + 1), id_char(base)};
    endfunction

    // Transmit sink: choose ready for the coming edge, then record a handshake.
    always @(negedge clk) begin
        tx_ready = tx_rand ? (($urandom % 3) != 0) : tx_force;
        #1;
        if (tx_valid && tx_ready) begin
            tx_seen.push_back(tx_data);
            tx_last_seen.push_back(tx_last);
        end
    end

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2 d = bus_rdata;
        @(posedge clk);
        #1 bus_sel = 1'b0;
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] w);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = w;
        @(posedge clk);
        #1 bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit last);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b; rx_last = last;
        #1;
        while (!rx_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1 rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    task automatic send_frame(input int len);
        frm.delete();
        for (int i = 0; i < len; i++) frm.push_back(8'($urandom));
        for (int i = 0; i < len; i++) send_byte(frm[i], i == len - 1);
    endtask

    task automatic drain(input int len);
        logic [31:0] d;
        for (int i = 0; i < len; i++) begin
            bus_read(6'h1C, d);
            chk_eq("R4 rx byte", d, {24'd0, frm[i]});
            bus_read(6'h0C, d);
            chk_eq("R4 rx count step", d, len - 1 - i);
        end
    endtask

    task automatic tx_collect(input int len, input string req);
        logic [31:0] d;
        int waited = 0;
        while (tx_seen.size() < len && waited < 400) begin
            @(negedge clk);
            waited++;
        end
        repeat (3) @(negedge clk);
        chk_eq({req, " tx length"}, tx_seen.size(), len);
        for (int i = 0; i < len && i < tx_seen.size(); i++) begin
            chk_eq({req, " tx byte"}, tx_seen[i], frm[i]);
            chk_eq({req, " tx last"}, tx_last_seen[i], i == len - 1);
        end
        bus_read(6'h10, d);
        chk_eq("R10 tx count cleared", d, 0);
    endtask

    task automatic tx_frame(input int len);
        frm.delete();
        tx_seen.delete();
        tx_last_seen.delete();
        bus_write(6'h10, len);
        for (int i = 0; i < len; i++) begin
            frm.push_back(8'($urandom));
            bus_write(6'h20, {24'($urandom), frm[i]});
        end
        tx_collect(len, "R9");
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        bus_read(6'h08, d); chk_eq("R11 reset busy", d, 0);
        bus_read(6'h0C, d); chk_eq("R3 reset rx count", d, 0);
        bus_read(6'h10, d); chk_eq("R8 reset tx count", d, 0);
        chk_eq("R6 reset rx_ready", rx_ready, 1);
        chk_eq("R9 reset tx_valid", tx_valid, 0);

        // R1 identity
        bus_read(6'h00, d); chk_eq("R1 id low", d, id_half(0));
        bus_read(6'h04, d); chk_eq("R1 id high", d, id_half(4));

        // R2 info and empty offsets
        bus_read(6'h18, d); chk_eq("R2 info", d, INFO);
        bus_read(6'h14, d); chk_eq("R2 irq ctl offset", d, 0);
        bus_read(6'h3C, d); chk_eq("R2 unmapped", d, 0);
        bus_read(6'h20, d); chk_eq("R2 tx data reads zero", d, 0);
        bus_write(6'h0C, 32'd7);
        bus_read(6'h0C, d); chk_eq("R2 rx count not writable", d, 0);
        bus_write(6'h08, 32'd1);
        bus_read(6'h08, d); chk_eq("R2 busy not writable", d, 0);

        // R5 empty read
        bus_read(6'h1C, d); chk_eq("R5 empty read data", d, 0);
        bus_read(6'h0C, d); chk_eq("R5 empty read count", d, 0);

        // R3 / R4 directed frame
        send_frame(3);
        bus_read(6'h0C, d); chk_eq("R3 rx count load", d, 3);
        drain(3);
        bus_read(6'h1C, d); chk_eq("R5 read after drain", d, 0);

        // R6 blocking by pending bytes, then by flag
        send_frame(2);
        @(negedge clk); rx_valid = 1'b1; rx_data = 8'hEE; rx_last = 1'b1;
        #1 chk_eq("R6 ready low with bytes held", rx_ready, 0);
        repeat (3) @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
        bus_read(6'h0C, d); chk_eq("R6 count unchanged", d, 2);
        drain(2);
        rx_hold = 1'b1;
        @(negedge clk); #1 chk_eq("R6 ready low with flag", rx_ready, 0);
        rx_hold = 1'b0;
        #1 chk_eq("R6 ready back", rx_ready, 1);

        // R7 oversize drop and exact fit
        send_frame(DEPTH + 4);
        bus_read(6'h0C, d); chk_eq("R7 oversize dropped", d, 0);
        send_frame(DEPTH);
        bus_read(6'h0C, d); chk_eq("R7 full depth kept", d, DEPTH);
        drain(DEPTH);

        // R11 busy during capture
        frm.delete(); frm.push_back(8'h5A); frm.push_back(8'hC3);
        send_byte(frm[0], 1'b0);
        bus_read(6'h08, d); chk_eq("R11 busy mid frame", d, 1);
        send_byte(frm[1], 1'b1);
        bus_read(6'h08, d); chk_eq("R11 busy after frame", d, 0);
        drain(2);

        // R8 count write filtering
        bus_write(6'h10, 32'd0);
        bus_read(6'h10, d); chk_eq("R8 zero ignored", d, 0);
        bus_write(6'h10, DEPTH + 1);
        bus_read(6'h10, d); chk_eq("R8 too large ignored", d, 0);

        // R9/R10/R11 stalled transmit with ignored writes
        tx_rand = 1'b0; tx_force = 1'b0;
        frm.delete(); tx_seen.delete(); tx_last_seen.delete();
        frm.push_back(8'h11); frm.push_back(8'h22);
        bus_write(6'h10, 32'd2);
        bus_write(6'h10, 32'd5);
        bus_read(6'h10, d); chk_eq("R8 rewrite ignored", d, 2);
        bus_write(6'h20, 32'hFFFF_FF11);
        #1 chk_eq("R9 no valid before full", tx_valid, 0);
        bus_write(6'h20, 32'h1234_5622);
        bus_write(6'h20, 32'h0000_0099);
        bus_write(6'h10, 32'd4);
        bus_read(6'h10, d); chk_eq("R8 write while streaming", d, 2);
        bus_read(6'h08, d); chk_eq("R11 busy while streaming", d, 1);
        @(negedge clk); #2 chk_eq("R10 held byte", tx_data, 8'h11);
        tx_rand = 1'b1;
        tx_collect(2, "R9 stalled");
        chk_eq("R9 valid low after", tx_valid, 0);

        tx_frame(DEPTH);

        // Random traffic
        for (int k = 0; k < 12; k++) begin
            int len = 1 + ($urandom % (DEPTH + 6));
            send_frame(len);
            bus_read(6'h0C, d); chk_eq("R3/R7 random rx count", d, exp_rx_count(len));
            if (exp_rx_count(len) != 0) drain(len);
        end
        for (int k = 0; k < 12; k++) begin
            tx_frame(1 + ($urandom % DEPTH));
        end

        summary();
        $finish;
    end

endmodule